// File: doc/BRIEF.md
# Integer ALU and Barrel Shifter

A purely combinational 32-bit arithmetic and logic unit for a load/store RISC integer pipeline. The execute stage gives it two register or immediate operands, a 5-bit constant shift amount taken from the instruction, and an operation code. The block returns a 32-bit result and a flag that requests an overflow exception. Immediate sign or zero extension happens upstream, so an extended immediate simply arrives on `b_i`.

The unit covers addition and subtraction, each in a trapping and a non-trapping form. It also has four bitwise operations, signed and unsigned compare-and-set, and loading a constant into the upper half-word. Shifts go left logical, right logical or right arithmetic, by either the constant amount or a variable amount taken from a register. The result is always driven, even when the overflow flag is raised. Suppressing the register write and taking the exception are left to the pipeline.

Top module: `int_alu`

## Requirements
- R1: Op 0 (ADD) and op 1 (ADDU) output `a_i + b_i` modulo 2^32.
- R2: Op 2 (SUB) and op 3 (SUBU) output `a_i - b_i` modulo 2^32.
- R3: `ovf_o` is 1 for ADD and SUB exactly when the two's-complement result overflows, and `result_o` still carries the wrapped value.
- R4: `ovf_o` is 0 for ADDU, SUBU and every operation other than ADD and SUB, whatever the operands.
- R5: Op 4 gives `a_i & b_i`, op 5 gives `a_i | b_i`, op 6 gives `a_i ^ b_i`, and op 7 gives `~(a_i | b_i)`.
- R6: Op 8 (SLT) outputs 1 when `a_i < b_i` as signed two's-complement numbers, otherwise 0. Bits 31..1 are always 0.
- R7: Op 9 (SLTU) outputs 1 when `a_i < b_i` as unsigned numbers, otherwise 0.
- R8: Op 10 (LUI) outputs `{b_i[15:0], 16'h0000}`.
- R9: Op 11 shifts `b_i` left by `shamt_i`, and op 12 shifts it right by `shamt_i`. Both fill with zeros.
- R10: Op 13 shifts `b_i` right by `shamt_i` and fills with copies of `b_i[31]`. Op 16 does the same with the variable amount.
- R11: Ops 14, 15 and 16 (left logical, right logical and right arithmetic) take the amount from `a_i[4:0]` only. Bits 31..5 of `a_i` and all of `shamt_i` have no effect on them.
- R12: A shift amount of 0 returns `b_i` unchanged, and an amount of 31 moves a single bit across the whole word.
- R13: Op codes 17 to 31 output 0 with `ovf_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand; also the variable shift amount in its low 5 bits |
| b_i | input | 32 | Second operand, or an extended immediate; the value being shifted |
| shamt_i | input | 5 | Constant shift amount from the instruction |
| op_i | input | 5 | Operation code |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed-overflow exception request |

## Verification
Immediate assertions inside the RTL check on every evaluation that the overflow flag stays low on the non-trapping and non-arithmetic codes. They also check that a flagged add or subtract has a result sign that disagrees with the operands, that compare results are 0 or 1, that the load-upper low half is cleared, that an arithmetic right shift keeps the sign bit, and that a zero shift passes its input through. The exact numbers can only be shown by the bench's scenarios. These include overflow at both ends of the signed range, compares where signed and unsigned order disagree, shift amounts of 0 and 31, variable amounts whose upper operand bits are set, and unused codes.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,
    OP_SLTU = 5'd9,
    OP_LUI  = 5'd10,
    OP_SLL  = 5'd11,
    OP_SRL  = 5'd12,
    OP_SRA  = 5'd13,
    OP_SLLV = 5'd14,
    OP_SRLV = 5'd15,
    OP_SRAV = 5'd16
  } alu_op_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  assign b_eff   = sub_i ? ~b_i : b_i;
  assign full    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
  // same-sign inputs producing a different-sign sum
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] nor_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign xor_o = a_i ^ b_i;
  assign nor_o = ~or_o;
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] rev_in, rev_out, core_out;
  logic [W-1:0] stg [SW+1];
  logic         fill;

  // left shift = reverse, shift right, reverse
  for (genvar k = 0; k < W; k++) begin : g_rev
    assign rev_in[k]  = data_i[W-1-k];
    assign rev_out[k] = core_out[W-1-k];
  end

  assign fill   = arith_i & ~left_i & data_i[W-1];
  assign stg[0] = left_i ? rev_in : data_i;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int S = 1 << i;
    assign stg[i+1] = amt_i[i] ? {{S{fill}}, stg[i][W-1:S]} : stg[i];
  end

  assign core_out = stg[SW];
  assign data_o   = left_i ? rev_out : core_out;

  always_comb begin
    // R12
    if (amt_i == '0) zero_shift_chk: assert (data_o == data_i);
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W),
  parameter int OW = 5
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [SW-1:0] shamt_i,
  input  logic [OW-1:0] op_i,
  output logic [W-1:0]  result_o,
  output logic          ovf_o
);
  localparam int HALF = W / 2;

  alu_op_e      op;
  logic         is_sub, shl, sh_ar, sh_var;
  logic [W-1:0] sum, and_r, or_r, xor_r, nor_r, sh_r;
  logic         carry, ovf_raw, lt_s, lt_u;
  logic [SW-1:0] amt;

  assign op = alu_op_e'(op_i);

  always_comb begin
    is_sub = 1'b0;
    unique case (op)
      OP_SUB, OP_SUBU, OP_SLT, OP_SLTU: is_sub = 1'b1;
      default: is_sub = 1'b0;
    endcase
  end

  int_alu_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(is_sub),
    .sum_o(sum), .carry_o(carry), .ovf_o(ovf_raw)
  );

  int_alu_logic #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i),
    .and_o(and_r), .or_o(or_r), .xor_o(xor_r), .nor_o(nor_r)
  );

  assign lt_s = sum[W-1] ^ ovf_raw;
  assign lt_u = ~carry;

  assign shl    = (op == OP_SLL)  || (op == OP_SLLV);
  assign sh_ar  = (op == OP_SRA)  || (op == OP_SRAV);
  assign sh_var = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
  assign amt    = sh_var ? a_i[SW-1:0] : shamt_i;

  int_alu_shift #(.W(W), .SW(SW)) u_shift (
    .data_i(b_i), .amt_i(amt), .left_i(shl), .arith_i(sh_ar), .data_o(sh_r)
  );

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        result_o = sum;
        ovf_o    = ovf_raw;
      end
      OP_ADDU, OP_SUBU:           result_o = sum;
      OP_AND:                     result_o = and_r;
      OP_OR:                      result_o = or_r;
      OP_XOR:                     result_o = xor_r;
      OP_NOR:                     result_o = nor_r;
      OP_SLT:                     result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:                    result_o = {{(W-1){1'b0}}, lt_u};
      OP_LUI:                     result_o = {b_i[HALF-1:0], {HALF{1'b0}}};
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV:  result_o = sh_r;
      default: begin
        result_o = '0;
        ovf_o    = 1'b0;
      end
    endcase
  end

  always_comb begin
    // R4
    if (op == OP_ADDU || op == OP_SUBU || op == OP_SLT || op == OP_SLTU)
      no_overflow_chk: assert (!ovf_o);
    // R3
    if (ovf_o && op == OP_ADD)
      add_ovf_sign_chk: assert (result_o[W-1] != a_i[W-1] && a_i[W-1] == b_i[W-1]);
    // R3
    if (ovf_o && op == OP_SUB)
      sub_ovf_sign_chk: assert (result_o[W-1] != a_i[W-1] && a_i[W-1] != b_i[W-1]);
    // R6
    if (op == OP_SLT || op == OP_SLTU)
      slt_bool_chk: assert (result_o[W-1:1] == '0);
    // R8
    if (op == OP_LUI)
      lui_low_chk: assert (result_o[HALF-1:0] == '0);
    // R10
    if (op == OP_SRA || op == OP_SRAV)
      sra_sign_chk: assert (result_o[W-1] == b_i[W-1]);
  end
endmodule

// File: tb/int_alu_tb.sv
`timescale 1ns/1ps
module int_alu_tb;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [4:0]  sh, op;
  logic [31:0] res;
  logic        ovf;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] r;
    logic        v;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  int_alu u_dut (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op),
    .result_o(res), .ovf_o(ovf)
  );

  function automatic exp_t model(input logic [4:0] o, input logic [31:0] x,
                                 input logic [31:0] y, input logic [4:0] s);
    exp_t e;
    logic signed [32:0] w;
    e.r = '0; e.v = 1'b0; e.tag = "R13";
    case (o)
      5'd0: begin w = $signed({x[31], x}) + $signed({y[31], y});
              e.r = x + y; e.v = w[32] != w[31]; e.tag = "R3"; end
      5'd1: begin e.r = x + y; e.tag = "R1"; end
      5'd2: begin w = $signed({x[31], x}) - $signed({y[31], y});
              e.r = x - y; e.v = w[32] != w[31]; e.tag = "R3"; end
      5'd3: begin e.r = x - y; e.tag = "R2"; end
      5'd4: begin e.r = x & y; e.tag = "R5"; end
      5'd5: begin e.r = x | y; e.tag = "R5"; end
      5'd6: begin e.r = x ^ y; e.tag = "R5"; end
      5'd7: begin e.r = ~(x | y); e.tag = "R5"; end
      5'd8: begin e.r = {31'd0, $signed(x) < $signed(y)}; e.tag = "R6"; end
      5'd9: begin e.r = {31'd0, x < y}; e.tag = "R7"; end
      5'd10: begin e.r = {y[15:0], 16'h0}; e.tag = "R8"; end
      5'd11: begin e.r = y << s; e.tag = "R9"; end
      5'd12: begin e.r = y >> s; e.tag = "R9"; end
      5'd13: begin e.r = $unsigned($signed(y) >>> s); e.tag = "R10"; end
      5'd14: begin e.r = y << x[4:0]; e.tag = "R11"; end
      5'd15: begin e.r = y >> x[4:0]; e.tag = "R11"; end
      5'd16: begin e.r = $unsigned($signed(y) >>> x[4:0]); e.tag = "R11"; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [4:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic [4:0] s, input string tag);
    exp_t e;
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    e = model(o, x, y, s);
    if (tag != "") e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: sample at posedge, inputs changed at negedge
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (res !== e.r || ovf !== e.v) begin
        n_errors++;
        $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got res=%h ovf=%b exp res=%h ovf=%b",
                 e.tag, op, a, b, sh, res, ovf, e.r, e.v);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx;
    op = '0; a = '0; b = '0; sh = '0;
    drive(5'd0, 32'h0, 32'h0, 5'd0, "R1");                   // quiet inputs
    drive(5'd1, 32'd5, 32'd7, 5'd0, "R1");
    drive(5'd1, 32'hFFFF_FFFF, 32'h1, 5'd0, "R1");
    drive(5'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, "R3");           // +overflow, wrapped result
    drive(5'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, "R3");   // -overflow
    drive(5'd0, 32'hFFFF_FFFF, 32'h1, 5'd0, "R3");           // no overflow
    drive(5'd3, 32'd10, 32'd3, 5'd0, "R2");
    drive(5'd2, 32'h8000_0000, 32'h1, 5'd0, "R3");
    drive(5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R3");
    drive(5'd1, 32'h7FFF_FFFF, 32'h1, 5'd0, "R4");
    drive(5'd3, 32'h8000_0000, 32'h1, 5'd0, "R4");
    drive(5'd4, 32'h7FFF_FFFF, 32'h1, 5'd0, "R4");
    drive(5'd8, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, "R4");
    drive(5'd4, 32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0, "R5");
    drive(5'd5, 32'hF0F0_1234, 32'h0FF0_0000, 5'd0, "R5");
    drive(5'd6, 32'hAAAA_5555, 32'hFFFF_0000, 5'd0, "R5");
    drive(5'd7, 32'h0000_00F0, 32'h0F00_0000, 5'd0, "R5");
    drive(5'd8, 32'hFFFF_FFFF, 32'h1, 5'd0, "R6");
    drive(5'd8, 32'h5, 32'h5, 5'd0, "R6");
    drive(5'd8, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, "R6");
    drive(5'd9, 32'hFFFF_FFFF, 32'h1, 5'd0, "R7");
    drive(5'd9, 32'h1, 32'h2, 5'd0, "R7");
    drive(5'd10, 32'hDEAD_BEEF, 32'hABCD_1234, 5'd0, "R8");
    drive(5'd11, 32'h0, 32'h1, 5'd31, "R12");
    drive(5'd12, 32'h0, 32'h8000_0000, 5'd31, "R12");
    drive(5'd13, 32'h0, 32'h8000_0000, 5'd31, "R12");
    drive(5'd13, 32'h0, 32'h8765_4321, 5'd0, "R12");
    drive(5'd11, 32'h0, 32'h8765_4321, 5'd0, "R12");
    drive(5'd12, 32'h0, 32'hF000_000F, 5'd4, "R9");
    drive(5'd11, 32'h0, 32'hF000_000F, 5'd4, "R9");
    drive(5'd13, 32'h0, 32'h8000_0000, 5'd4, "R10");
    drive(5'd13, 32'h0, 32'h4000_0000, 5'd4, "R10");
    drive(5'd16, 32'h0000_0004, 32'h9000_0000, 5'd0, "R10");
    drive(5'd14, 32'hFFFF_FFE3, 32'h0000_00FF, 5'd17, "R11");
    drive(5'd15, 32'h1234_5660, 32'hFFFF_0000, 5'd9, "R11");
    drive(5'd16, 32'hFFFF_FFFF, 32'h8000_0000, 5'd2, "R11");
    drive(5'd14, 32'h0000_0000, 32'h0000_0001, 5'd31, "R11");
    drive(5'd17, 32'h7FFF_FFFF, 32'h1, 5'd3, "R13");
    drive(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, "R13");
    rx = 32'h1357_9BDF;
    for (int i = 0; i < 96; i++) begin
      logic [31:0] ry;
      rx = rx ^ (rx << 13); rx = rx ^ (rx >> 17); rx = rx ^ (rx << 5);
      ry = {rx[15:0], rx[31:16]} ^ 32'hA5A5_5A5A;
      drive(5'(i % 18), rx, ry, rx[9:5], "");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule